// File: doc/BRIEF.md
# Paged Processor Access Port

This block is the slave end of a non-multiplexed 8-bit processor bus for a time slot switch. The bus has six address lines, an active-low select, an active-high strobe, a read line and an active-low completion signal. All bus inputs pass through a two-flop synchronizer into the switch clock domain before they are decoded. A low address bit 5 reaches an 8-bit control register. A high address bit 5 reaches one 32-entry window of the switch memories. The control register chooses both the window's stream (its page) and the target memory: data memory, connection-low memory or connection-high memory.

Accesses to a memory go to the switch core as a request. The request carries the target, the 8-bit index (page and channel), the direction and the write byte. The request is held until the core grants it, because the core shares the memories with the TDM ports. The completion signal goes low only once the transfer has finished, so its delay follows the grant. It stays low until the strobe is removed. A split mode sends reads to the data memory and writes to the connection-low memory. One control bit is brought out to force every output channel into processor mode.

Top module: `paged_access_port`

## Requirements
- R1: With address bit 5 low, the access reaches the control register whatever address bits 4..0 hold. A read returns the stored byte with bit 5 always 0. The register keeps its value except on a control-register write.
- R2: With address bit 5 high, `core_index` equals {control bits 2..0, address bits 4..0}.
- R3: When split mode is off, control bits 4..3 select the target, with `core_target` using the same code: 01 data memory, 10 connection-low, 11 connection-high.
- R4: Select code 00 is acknowledged without any request. A read then returns 0, and a write changes no memory.
- R5: When control bit 7 is 1, reads target the data memory and writes target the connection-low memory, whatever bits 4..3 hold.
- R6: A write aimed at the data memory is acknowledged without a request and leaves the data memory unchanged.
- R7: `all_proc_mode` equals control bit 6.
- R8: An access begins when the synchronized select is low and the synchronized strobe is high. Inputs applied before rising edge k take effect at edge k+2. For a control-register or no-request access, `bus_done_n` falls after that edge.
- R9: `core_req` rises after the edge where the access begins. It holds with a stable index, target, direction and write byte until `core_grant` is sampled high. On that edge the request drops and `bus_done_n` falls, and `bus_done_n` is never low while a request is pending.
- R10: `bus_done_n` stays low until the synchronized strobe is seen low, then returns high. `bus_dout_en` is high only while `bus_done_n` is low on a read, and `bus_dout` is 0 otherwise.
- R11: After reset, `bus_done_n` is 1, `bus_dout_en` and `core_req` are 0, and the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Active-low select |
| bus_strobe | input | 1 | Active-high data strobe |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Bus address |
| bus_din | input | 8 | Write byte from the processor |
| bus_dout | output | 8 | Read byte to the processor |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |
| bus_done_n | output | 1 | Active-low transfer-complete signal |
| core_req | output | 1 | Memory request to the switch core |
| core_target | output | 2 | Requested memory (01 data, 10 conn-low, 11 conn-high) |
| core_write | output | 1 | Request is a write |
| core_index | output | 8 | Stream and channel index of the request |
| core_wdata | output | 8 | Write byte of the request |
| core_grant | input | 1 | Core grants the pending request this cycle |
| core_rdata | input | 8 | Read byte, valid while `core_grant` is high |
| all_proc_mode | output | 1 | Global processor-mode control bit |

## Verification
The assertions check on every cycle that a pending request holds its fields until it is granted. They also check that completion never coincides with a pending request and that read data is driven only during completion. They further check that completion is released only after the strobe is seen low, that no request ever writes the data memory, and that the control register changes only on its own writes. Only the bench's scenarios can show the decoding itself: the paging, the target chosen by select code and split mode, and the read values returned. They also show the exact latency from strobe to completion under different grant delays and that no-op accesses leave the memories untouched.

// File: rtl/pgp_pkg.sv
package pgp_pkg;
  localparam int BYTE_W  = 8;
  localparam int CHAN_W  = 5;
  localparam int PAGE_W  = 3;
  localparam int ADDR_W  = CHAN_W + 1;
  localparam int INDEX_W = PAGE_W + CHAN_W;

  typedef enum logic [1:0] {
    TGT_NONE    = 2'b00,
    TGT_DATA    = 2'b01,
    TGT_CONN_LO = 2'b10,
    TGT_CONN_HI = 2'b11
  } target_e;

  // bit positions are software visible
  typedef struct packed {
    logic              split;
    logic              all_proc;
    logic              spare;
    logic [1:0]        mem_sel;
    logic [PAGE_W-1:0] page;
  } ctl_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/pgp_sync.sv
module pgp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pgp_ctlreg.sv
module pgp_ctlreg
  import pgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output ctl_t              ctl_q
);
  ctl_t ctl_nxt;

  always_comb begin
    ctl_nxt       = ctl_t'(wdata);
    ctl_nxt.spare = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_nxt;
  end

  // R1: register only changes on its own write
  p_ctl_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/pgp_decode.sv
module pgp_decode
  import pgp_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_read,
  input  ctl_t               ctl,
  output logic               hit_ctl,
  output target_e            target,
  output logic [INDEX_W-1:0] index,
  output logic               needs_core
);
  always_comb begin
    hit_ctl = !addr[ADDR_W-1];
    index   = {ctl.page, addr[CHAN_W-1:0]};
    if (ctl.split) target = is_read ? TGT_DATA : TGT_CONN_LO;
    else           target = target_e'(ctl.mem_sel);
    needs_core = !hit_ctl && (target != TGT_NONE) &&
                 !((target == TGT_DATA) && !is_read);
  end
endmodule

// File: rtl/paged_access_port.sv
module paged_access_port
  import pgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel_n,
  input  logic               bus_strobe,
  input  logic               bus_read,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0]  bus_din,
  output logic [BYTE_W-1:0]  bus_dout,
  output logic               bus_dout_en,
  output logic               bus_done_n,
  output logic               core_req,
  output logic [1:0]         core_target,
  output logic               core_write,
  output logic [INDEX_W-1:0] core_index,
  output logic [BYTE_W-1:0]  core_wdata,
  input  logic               core_grant,
  input  logic [BYTE_W-1:0]  core_rdata,
  output logic               all_proc_mode
);
  localparam int BUNDLE_W = 3 + ADDR_W + BYTE_W;
  localparam logic [BUNDLE_W-1:0] IDLE_BUNDLE = {1'b1, {(BUNDLE_W-1){1'b0}}};

  logic [BUNDLE_W-1:0] bundle_s;
  logic                s_sel_n, s_strobe, s_read;
  logic [ADDR_W-1:0]   s_addr;
  logic [BYTE_W-1:0]   s_din;

  pgp_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_BUNDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({bus_sel_n, bus_strobe, bus_read, bus_addr, bus_din}),
    .dout(bundle_s)
  );

  assign {s_sel_n, s_strobe, s_read, s_addr, s_din} = bundle_s;

  ctl_t               ctl_q;
  logic               hit_ctl, needs_core, ctl_wr, active;
  target_e            dec_target;
  logic [INDEX_W-1:0] dec_index;
  phase_e             phase_q;
  logic               rd_flag_q;

  assign active = !s_sel_n && s_strobe;
  assign ctl_wr = (phase_q == PH_IDLE) && active && hit_ctl && !s_read;

  pgp_decode u_decode (
    .addr      (s_addr),
    .is_read   (s_read),
    .ctl       (ctl_q),
    .hit_ctl   (hit_ctl),
    .target    (dec_target),
    .index     (dec_index),
    .needs_core(needs_core)
  );

  pgp_ctlreg u_ctl (
    .clk  (clk),
    .rst  (rst),
    .wr_en(ctl_wr),
    .wdata(s_din),
    .ctl_q(ctl_q)
  );

  assign all_proc_mode = ctl_q.all_proc;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      bus_done_n  <= 1'b1;
      bus_dout_en <= 1'b0;
      bus_dout    <= '0;
      core_req    <= 1'b0;
      core_target <= TGT_NONE;
      core_write  <= 1'b0;
      core_index  <= '0;
      core_wdata  <= '0;
      rd_flag_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (active) begin
            if (hit_ctl) begin
              phase_q     <= PH_DONE;
              bus_done_n  <= 1'b0;
              bus_dout_en <= s_read;
              bus_dout    <= s_read ? BYTE_W'(ctl_q) : '0;
            end else if (needs_core) begin
              phase_q     <= PH_WAIT;
              core_req    <= 1'b1;
              core_target <= dec_target;
              core_write  <= !s_read;
              core_index  <= dec_index;
              core_wdata  <= s_din;
              rd_flag_q   <= s_read;
            end else begin
              phase_q     <= PH_DONE;
              bus_done_n  <= 1'b0;
              bus_dout_en <= s_read;
              bus_dout    <= '0;
            end
          end
        end
        PH_WAIT: begin
          if (core_grant) begin
            core_req    <= 1'b0;
            phase_q     <= PH_DONE;
            bus_done_n  <= 1'b0;
            bus_dout_en <= rd_flag_q;
            bus_dout    <= rd_flag_q ? core_rdata : '0;
          end
        end
        PH_DONE: begin
          if (!s_strobe) begin
            phase_q     <= PH_IDLE;
            bus_done_n  <= 1'b1;
            bus_dout_en <= 1'b0;
            bus_dout    <= '0;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R9: request fields held until granted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    core_req && !core_grant |=> core_req && $stable(core_index) &&
      $stable(core_target) && $stable(core_write) && $stable(core_wdata));

  // R9: no completion while a request is pending
  p_no_done_in_req_r9: assert property (@(posedge clk) disable iff (rst)
    core_req |-> bus_done_n);

  // R10: read data driven only during completion
  p_dout_in_done_r10: assert property (@(posedge clk) disable iff (rst)
    bus_dout_en |-> !bus_done_n);

  // R10: completion released only after strobe seen low
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_done_n) |-> !$past(s_strobe));

  // R6: data memory never written through a request
  p_no_dm_write_r6: assert property (@(posedge clk) disable iff (rst)
    core_req |-> !((core_target == TGT_DATA) && core_write));
endmodule

// File: tb/paged_access_port_test.sv
module paged_access_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       bus_sel_n = 1'b1, bus_strobe = 1'b0, bus_read = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_dout_en, bus_done_n;
  logic       core_req, core_write, core_grant = 1'b0;
  logic [1:0] core_target;
  logic [7:0] core_index, core_wdata, core_rdata;
  logic       all_proc_mode;

  logic [7:0] dm [256];
  logic [7:0] cml [256];
  logic [7:0] cmh [256];

  int compared = 0, mismatched = 0;
  int lat = 0;
  bit done_flag = 0;

  paged_access_port uut (
    .clk(clk), .rst(rst),
    .bus_sel_n(bus_sel_n), .bus_strobe(bus_strobe), .bus_read(bus_read),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_done_n(bus_done_n),
    .core_req(core_req), .core_target(core_target), .core_write(core_write),
    .core_index(core_index), .core_wdata(core_wdata),
    .core_grant(core_grant), .core_rdata(core_rdata),
    .all_proc_mode(all_proc_mode)
  );

  assign core_rdata = (core_target == 2'b01) ? dm[core_index] :
                      (core_target == 2'b10) ? cml[core_index] :
                      (core_target == 2'b11) ? cmh[core_index] : 8'h00;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // core responder: grants after lat idle cycles, applies writes
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (rst) begin core_grant = 1'b0; cnt = 0; end
      else if (core_grant) core_grant = 1'b0;
      else if (core_req) begin
        if (cnt >= lat) begin
          core_grant = 1'b1;
          cnt = 0;
          if (core_write) begin
            if (core_target == 2'b10) cml[core_index] = core_wdata;
            else if (core_target == 2'b11) cmh[core_index] = core_wdata;
            else if (core_target == 2'b01) dm[core_index] = core_wdata;
          end
        end else cnt++;
      end
    end
  end

  // cycle reference model
  logic [16:0] pipe [$];
  int          m_phase;
  logic [7:0]  m_ctl, m_dout, m_idx, m_wdata;
  logic        m_done_n, m_oe, m_req, m_write, m_rdflag;
  logic [1:0]  m_tgt;
  logic [16:0] d;
  logic [1:0]  t;

  always @(posedge clk) begin
    if (rst) begin
      pipe.delete();
      pipe.push_back(17'h10000);
      pipe.push_back(17'h10000);
      m_phase = 0; m_ctl = 0; m_dout = 0; m_done_n = 1; m_oe = 0;
      m_req = 0; m_write = 0; m_idx = 0; m_wdata = 0; m_tgt = 0; m_rdflag = 0;
    end else begin
      d = pipe.pop_front();
      pipe.push_back({bus_sel_n, bus_strobe, bus_read, bus_addr, bus_din});
      if (m_phase == 0) begin
        if (!d[16] && d[15]) begin
          if (!d[13]) begin
            m_dout = d[14] ? m_ctl : 8'h00;
            if (!d[14]) m_ctl = d[7:0] & 8'hDF;
            m_phase = 2; m_done_n = 0; m_oe = d[14];
          end else begin
            t = m_ctl[7] ? (d[14] ? 2'b01 : 2'b10) : m_ctl[4:3];
            if (t == 2'b00 || (t == 2'b01 && !d[14])) begin
              m_phase = 2; m_done_n = 0; m_oe = d[14]; m_dout = 0;
            end else begin
              m_phase = 1; m_req = 1; m_tgt = t; m_write = !d[14];
              m_idx = {m_ctl[2:0], d[12:8]}; m_wdata = d[7:0]; m_rdflag = d[14];
            end
          end
        end
      end else if (m_phase == 1) begin
        if (core_grant) begin
          m_req = 0; m_phase = 2; m_done_n = 0; m_oe = m_rdflag;
          m_dout = m_rdflag ? core_rdata : 8'h00;
        end
      end else begin
        if (!d[15]) begin
          m_phase = 0; m_done_n = 1; m_oe = 0; m_dout = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(bus_done_n == m_done_n, "R10 done", bus_done_n, m_done_n);
      check(bus_dout_en == m_oe, "R10 dout_en", bus_dout_en, m_oe);
      check(bus_dout == m_dout, "R10 dout", bus_dout, m_dout);
      check(core_req == m_req, "R8 core_req", core_req, m_req);
      check(all_proc_mode == m_ctl[6], "R7 mode", all_proc_mode, m_ctl[6]);
      if (m_req) begin
        check(core_index == m_idx, "R2 index", core_index, m_idx);
        check(core_target == m_tgt, "R3 target", core_target, m_tgt);
        check({core_write, core_wdata} == {m_write, m_wdata}, "R9 fields",
              {core_write, core_wdata}, {m_write, m_wdata});
      end
    end
  end

  task automatic xfer(input bit rd, input logic [5:0] a, input logic [7:0] dv,
                      output logic [7:0] q, output int cyc);
    int n;
    @(negedge clk);
    bus_addr = a; bus_din = dv; bus_read = rd; bus_sel_n = 0; bus_strobe = 1;
    n = 0;
    while (bus_done_n && n < 300) begin @(negedge clk); n++; end
    if (bus_done_n) check(0, "R9 timeout", 0, 1);
    q = bus_dout; cyc = n;
    @(negedge clk);
    bus_strobe = 0; bus_sel_n = 1;
    n = 0;
    while (!bus_done_n && n < 50) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] c, input logic [4:0] ch);
    logic [7:0] i;
    logic [1:0] tt;
    i = {c[2:0], ch};
    tt = c[7] ? 2'b01 : c[4:3];
    case (tt)
      2'b01:   return dm[i];
      2'b10:   return cml[i];
      2'b11:   return cmh[i];
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int cyc;
    logic [7:0] cur_ctl;
    for (int i = 0; i < 256; i++) begin
      dm[i] = 8'(i) ^ 8'h5A; cml[i] = 8'h00; cmh[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(bus_done_n == 1, "R11 done_n", bus_done_n, 1);
    check(bus_dout_en == 0 && core_req == 0, "R11 idle", {bus_dout_en, core_req}, 0);
    xfer(1, 6'b000000, 0, q, cyc);
    check(q == 8'h00, "R11 ctl reset", q, 0);
    check(cyc == 3, "R8 ctl latency", cyc, 3);

    // R1 decoding ignores A4..A0, spare bit reads 0; R7
    xfer(0, 6'b011100, 8'hFF, q, cyc);
    xfer(1, 6'b000011, 0, q, cyc);
    check(q == 8'hDF, "R1 ctl readback", q, 8'hDF);
    check(all_proc_mode == 1, "R7 mode set", all_proc_mode, 1);

    // R2 R3 connection-low page 5
    lat = 0;
    xfer(0, 6'b000000, 8'h15, q, cyc);
    check(all_proc_mode == 0, "R7 mode clear", all_proc_mode, 0);
    xfer(0, 6'b100111, 8'hA3, q, cyc);
    check(cml[5*32+7] == 8'hA3, "R2 cml write", cml[5*32+7], 8'hA3);
    check(cyc == 4, "R9 grant latency", cyc, 4);
    xfer(1, 6'b100111, 0, q, cyc);
    check(q == 8'hA3, "R3 cml read", q, 8'hA3);

    // R3 R9 connection-high page 2, slow grant
    lat = 3;
    xfer(0, 6'b000000, 8'h1A, q, cyc);
    xfer(0, 6'b111111, 8'h41, q, cyc);
    check(cmh[2*32+31] == 8'h41, "R3 cmh write", cmh[2*32+31], 8'h41);
    check(cyc == 7, "R9 slow grant", cyc, 7);
    xfer(1, 6'b111111, 0, q, cyc);
    check(q == 8'h41, "R3 cmh read", q, 8'h41);

    // R3 R6 data memory page 6
    lat = 1;
    xfer(0, 6'b000000, 8'h0E, q, cyc);
    xfer(1, 6'b101001, 0, q, cyc);
    check(q == (8'd201 ^ 8'h5A), "R3 dm read", q, 8'd201 ^ 8'h5A);
    xfer(0, 6'b101001, 8'h00, q, cyc);
    check(cyc == 3, "R6 dm write no request", cyc, 3);
    check(dm[201] == (8'd201 ^ 8'h5A), "R6 dm unchanged", dm[201], 8'd201 ^ 8'h5A);

    // R4 select 00
    xfer(0, 6'b000000, 8'h01, q, cyc);
    xfer(1, 6'b100100, 0, q, cyc);
    check(q == 8'h00 && cyc == 3, "R4 read none", {q, 8'(cyc)}, 8'h03);
    xfer(0, 6'b100100, 8'hEE, q, cyc);
    check(cml[36] == 0 && cmh[36] == 0 && dm[36] == (8'd36 ^ 8'h5A), "R4 write none",
          {cml[36], cmh[36]}, 0);

    // R5 split mode with select 11
    xfer(0, 6'b000000, 8'h9C, q, cyc);
    xfer(0, 6'b100011, 8'h77, q, cyc);
    check(cml[131] == 8'h77 && cmh[131] == 0, "R5 split write", {cml[131], cmh[131]}, 16'h7700);
    xfer(1, 6'b100011, 0, q, cyc);
    check(q == (8'd131 ^ 8'h5A), "R5 split read", q, 8'd131 ^ 8'h5A);

    // R10 hold strobe long
    @(negedge clk);
    bus_addr = 6'b000000; bus_read = 1; bus_sel_n = 0; bus_strobe = 1;
    while (bus_done_n) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!bus_done_n && bus_dout_en, "R10 hold", {bus_done_n, bus_dout_en}, 2'b01);
    end
    bus_strobe = 0; bus_sel_n = 1;
    repeat (2) @(negedge clk);
    check(!bus_done_n, "R10 not yet released", bus_done_n, 0);
    @(negedge clk);
    check(bus_done_n && !bus_dout_en, "R10 released", {bus_done_n, bus_dout_en}, 2'b10);

    // mixed sweep
    cur_ctl = 8'h9C;
    for (int k = 0; k < 48; k++) begin
      logic [7:0] nc;
      logic [4:0] ch;
      lat = k % 4;
      nc = 8'((k * 37) & 8'hDF);
      if (nc[4:3] == 2'b00) nc[3] = 1'b1;
      xfer(0, 6'b010000, nc, q, cyc);
      cur_ctl = nc;
      ch = 5'((k * 11) % 32);
      xfer(0, {1'b1, ch}, 8'(k * 3 + 1), q, cyc);
      xfer(1, {1'b1, ch}, 0, q, cyc);
      check(q == exp_read(cur_ctl, ch), "R5 sweep read", q, exp_read(cur_ctl, ch));
    end

    repeat (5) @(negedge clk);
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule